// File: doc/BRIEF.md
# Outbound Message Descriptor Ring Engine

This block walks a circular ring of 32-byte outbound message descriptors held in system memory. Software sets the ring's base address and size, fills descriptors in memory, and then pulses a command bit in the mode register. Each pulse moves the enqueue pointer forward by one slot. While the unit is enabled and the dequeue pointer differs from the enqueue pointer, the engine does three things in a loop. It reads the descriptor at the dequeue address over a simple read port. It checks the transfer size. It then presents a send request to a downstream link stub, made of destination ID, mailbox, port index, size, source buffer address and slot number.

Every accepted send moves the dequeue pointer forward, wrapping to the base after the last slot, and raises end-of-message. The status register also records queue-empty, queue-full, enqueue overflow and transfer errors. A single interrupt line is the OR of the status bits that are enabled in the mode register. Building link packets and moving the payload are done elsewhere.

Top module: `obmsg_ring`

## Requirements
- R1: After reset the mode register reads 0xA2000000 (unit disabled, ring field 0, interrupt enables set for end-of-message, overflow and transfer error), status reads 0, irq is low, and neither mem_rd_req nor snd_valid is asserted.
- R2: A write of the mode register (address 0) with bit 1 set advances the enqueue pointer (address 3) by 32 bytes. After the last slot it wraps to the base (address 4). The ring holds 2^(mode[15:12]+2) entries, with the field clamped at 9. Bit 1 always reads back 0.
- R3: An advance whose next enqueue address equals the dequeue pointer (address 2) leaves the enqueue pointer unchanged and sets overflow, status bit 5.
- R4: An advance after which one more advance would reach the dequeue pointer sets queue-full, status bit 4.
- R5: While enabled (mode bit 0), without a pending transfer error and with the dequeue pointer unequal to the enqueue pointer, the engine reads the 32-byte descriptor at the dequeue address. It holds mem_rd_req and mem_rd_addr steady until mem_rd_valid. Descriptor word k is mem_rd_data[32k+31:32k]. It then holds a send request with these fields until snd_ready:
  - dest = word2[31:16]
  - mbox = word2[1:0]
  - port = word3[23:20]
  - size = word6
  - src = word1
  - slot = (dequeue - base) >> 5
- R6: Each accepted send advances the dequeue pointer by 32 bytes, wrapping like the enqueue pointer, and sets end-of-message, status bit 1. When the new dequeue pointer equals the enqueue pointer, it also sets queue-empty, status bit 0.
- R7: While mode bit 0 is clear, no descriptor read is started.
- R8: A read returned with mem_rd_err, or a size word that is below 8, above 4096 or not a power of two, sets transfer error, status bit 7. No send is made and the dequeue pointer does not move. No read starts while bit 7 stays set, and the same descriptor is fetched again after bit 7 is cleared.
- R9: Writing the status register (address 1) clears each bit written as 1 and leaves the others.
- R10: irq is high exactly when some status bit is set whose enable bit at the same position in mode[31:24] is set.
- R11: Writes to the dequeue, enqueue and base addresses take effect only while the unit is disabled. A base write also loads both pointers with the base address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select: 0 mode, 1 status, 2 dequeue, 3 enqueue, 4 base |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| mem_rd_req | output | 1 | Descriptor read request |
| mem_rd_addr | output | 32 | Descriptor byte address |
| mem_rd_valid | input | 1 | Descriptor data returned |
| mem_rd_data | input | 256 | Eight descriptor words, word 0 lowest |
| mem_rd_err | input | 1 | Read failed, qualified by mem_rd_valid |
| snd_valid | output | 1 | Send request pending |
| snd_ready | input | 1 | Link stub accepts the request |
| snd_dest | output | 16 | Destination ID |
| snd_mbox | output | 2 | Mailbox number |
| snd_port | output | 4 | Port index |
| snd_size | output | 32 | Transfer size in bytes |
| snd_src | output | 32 | Source buffer address |
| snd_slot | output | 11 | Ring slot of the descriptor |
| irq | output | 1 | Combined enabled status |

## Verification
The ring is first filled with the unit disabled, advancing until queue-full and then overflow appear. This separates the pointer bookkeeping from consumption. A burst of three descriptors then drains under a stalling link stub, with junk in the pad words and in the middle bits of the destination word, which exposes wrong field selection. A second burst crosses the wrap point on both pointers. A descriptor with a bad size and a read that returns an error both show that the engine stalls without moving the dequeue pointer and retries after the error is cleared. A final advance with the unit disabled must cause no read at all.

// File: rtl/obmsg_pkg.sv
package obmsg_pkg;

  localparam int PTR_W       = 32;
  localparam int DESC_BYTES  = 32;
  localparam int DESC_SHIFT  = 5;
  localparam int DESC_WORDS  = DESC_BYTES / 4;
  localparam int DESC_BITS   = DESC_BYTES * 8;
  localparam int SZF_MAX     = 9;
  localparam int SLOT_W      = SZF_MAX + 2;

  // descriptor word positions read by the link-side logic
  localparam int W_SRC   = 1;
  localparam int W_DPORT = 2;
  localparam int W_ATTR  = 3;
  localparam int W_SIZE  = 6;

  // register selects
  localparam logic [2:0] RA_MODE = 3'd0;
  localparam logic [2:0] RA_STAT = 3'd1;
  localparam logic [2:0] RA_DEQ  = 3'd2;
  localparam logic [2:0] RA_ENQ  = 3'd3;
  localparam logic [2:0] RA_BASE = 3'd4;

  // status bit positions
  localparam int SB_EMPTY = 0;
  localparam int SB_EOM   = 1;
  localparam int SB_FULL  = 4;
  localparam int SB_OVF   = 5;
  localparam int SB_TERR  = 7;
  localparam logic [7:0] STAT_MASK = 8'hB3;
  localparam logic [7:0] IE_RESET  = 8'hA2;

  typedef logic [PTR_W-1:0] ptr_t;
  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_SEND} eng_st_e;

  function automatic logic [SLOT_W-1:0] slot_of(input ptr_t p, input ptr_t b);
    ptr_t off;
    off = p - b;
    return off[SLOT_W+DESC_SHIFT-1:DESC_SHIFT];
  endfunction

  function automatic ptr_t ring_next(input ptr_t p, input ptr_t b, input logic [3:0] f);
    ptr_t off;
    logic [3:0] fc;
    off = p - b;
    fc  = (f > 4'(SZF_MAX)) ? 4'(SZF_MAX) : f;
    if ((off >> DESC_SHIFT) + 32'd1 >= (32'd1 << (fc + 4'd2)))
      return b;
    return p + ptr_t'(DESC_BYTES);
  endfunction

  function automatic logic size_ok(input logic [31:0] s, input logic [31:0] maxb);
    return (s >= 32'd8) && (s <= maxb) && ((s & (s - 32'd1)) == 32'd0);
  endfunction

endpackage

// File: rtl/obmsg_ctrl_regs.sv
module obmsg_ctrl_regs
  import obmsg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  ptr_t        deq_ptr,
  input  logic        evt_sent,
  input  logic        evt_empty,
  input  logic        evt_terr,
  output logic        mode_en,
  output logic [3:0]  size_fld,
  output ptr_t        base_ptr,
  output ptr_t        enq_ptr,
  output logic        deq_load,
  output ptr_t        deq_load_val,
  output logic [7:0]  status,
  output logic        irq,
  output logic        adv_cmd,
  output logic        ovf_evt
);

  logic [7:0] ie_mask;
  logic       ptr_wr_ok;
  logic       adv_ok;
  logic       full_evt;
  ptr_t       enq_nxt;
  logic [7:0] clr_vec;
  logic [7:0] set_vec;

  assign enq_nxt   = ring_next(enq_ptr, base_ptr, size_fld);
  assign adv_cmd   = reg_we && (reg_addr == RA_MODE) && reg_wdata[1];
  assign ovf_evt   = adv_cmd && (enq_nxt == deq_ptr);
  assign adv_ok    = adv_cmd && !ovf_evt;
  assign full_evt  = adv_ok && (ring_next(enq_nxt, base_ptr, size_fld) == deq_ptr);
  assign ptr_wr_ok = reg_we && !mode_en;

  assign deq_load     = ptr_wr_ok && ((reg_addr == RA_DEQ) || (reg_addr == RA_BASE));
  assign deq_load_val = reg_wdata;

  assign clr_vec = (reg_we && (reg_addr == RA_STAT)) ? reg_wdata[7:0] : 8'h00;

  always_comb begin
    set_vec           = 8'h00;
    set_vec[SB_EMPTY] = evt_empty;
    set_vec[SB_EOM]   = evt_sent;
    set_vec[SB_FULL]  = full_evt;
    set_vec[SB_OVF]   = ovf_evt;
    set_vec[SB_TERR]  = evt_terr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_en  <= 1'b0;
      size_fld <= 4'd0;
      ie_mask  <= IE_RESET;
      base_ptr <= '0;
      enq_ptr  <= '0;
      status   <= 8'h00;
    end else begin
      if (reg_we && (reg_addr == RA_MODE)) begin
        mode_en  <= reg_wdata[0];
        size_fld <= reg_wdata[15:12];
        ie_mask  <= reg_wdata[31:24];
      end
      if (adv_ok)
        enq_ptr <= enq_nxt;
      else if (ptr_wr_ok && ((reg_addr == RA_ENQ) || (reg_addr == RA_BASE)))
        enq_ptr <= reg_wdata;
      if (ptr_wr_ok && (reg_addr == RA_BASE))
        base_ptr <= reg_wdata;
      status <= ((status & ~clr_vec) | set_vec) & STAT_MASK;
    end
  end

  assign irq = |(status & ie_mask);

  always_comb begin
    case (reg_addr)
      RA_MODE: reg_rdata = {ie_mask, 8'h00, size_fld, 10'h000, 1'b0, mode_en};
      RA_STAT: reg_rdata = {24'h000000, status};
      RA_DEQ:  reg_rdata = deq_ptr;
      RA_ENQ:  reg_rdata = enq_ptr;
      RA_BASE: reg_rdata = base_ptr;
      default: reg_rdata = 32'h0;
    endcase
  end

endmodule

// File: rtl/obmsg_fetch_eng.sv
module obmsg_fetch_eng
  import obmsg_pkg::*;
#(
  parameter int unsigned MAX_MSG = 4096
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 mode_en,
  input  logic                 te_block,
  input  ptr_t                 base_ptr,
  input  ptr_t                 enq_ptr,
  input  logic [3:0]           size_fld,
  input  logic                 deq_load,
  input  ptr_t                 deq_load_val,
  output logic                 mem_rd_req,
  output ptr_t                 mem_rd_addr,
  input  logic                 mem_rd_valid,
  input  logic [DESC_BITS-1:0] mem_rd_data,
  input  logic                 mem_rd_err,
  output logic                 snd_valid,
  input  logic                 snd_ready,
  output logic [15:0]          snd_dest,
  output logic [1:0]           snd_mbox,
  output logic [3:0]           snd_port,
  output logic [31:0]          snd_size,
  output logic [31:0]          snd_src,
  output logic [SLOT_W-1:0]    snd_slot,
  output ptr_t                 deq_ptr,
  output logic                 evt_sent,
  output logic                 evt_empty,
  output logic                 evt_terr
);

  logic [31:0] dword [DESC_WORDS];

  for (genvar gi = 0; gi < DESC_WORDS; gi++) begin : g_word
    assign dword[gi] = mem_rd_data[32*gi +: 32];
  end

  eng_st_e st_q;
  ptr_t    deq_nxt;
  logic    fetch_bad;

  assign deq_nxt   = ring_next(deq_ptr, base_ptr, size_fld);
  assign fetch_bad = mem_rd_err || !size_ok(dword[W_SIZE], 32'(MAX_MSG));

  assign mem_rd_req  = (st_q == ST_FETCH);
  assign mem_rd_addr = deq_ptr;
  assign snd_valid   = (st_q == ST_SEND);
  assign evt_sent    = snd_valid && snd_ready;
  assign evt_empty   = evt_sent && (deq_nxt == enq_ptr);
  assign evt_terr    = mem_rd_req && mem_rd_valid && fetch_bad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      deq_ptr  <= '0;
      snd_dest <= '0;
      snd_mbox <= '0;
      snd_port <= '0;
      snd_size <= '0;
      snd_src  <= '0;
      snd_slot <= '0;
    end else begin
      case (st_q)
        ST_IDLE:
          if (mode_en && !te_block && (deq_ptr != enq_ptr))
            st_q <= ST_FETCH;
        ST_FETCH:
          if (mem_rd_valid) begin
            if (fetch_bad) begin
              st_q <= ST_IDLE;
            end else begin
              snd_dest <= dword[W_DPORT][31:16];
              snd_mbox <= dword[W_DPORT][1:0];
              snd_port <= dword[W_ATTR][23:20];
              snd_size <= dword[W_SIZE];
              snd_src  <= dword[W_SRC];
              snd_slot <= slot_of(deq_ptr, base_ptr);
              st_q     <= ST_SEND;
            end
          end
        ST_SEND:
          if (snd_ready)
            st_q <= ST_IDLE;
        default:
          st_q <= ST_IDLE;
      endcase
      if (deq_load)
        deq_ptr <= deq_load_val;
      else if (evt_sent)
        deq_ptr <= deq_nxt;
    end
  end

endmodule

// File: rtl/obmsg_ring.sv
module obmsg_ring
  import obmsg_pkg::*;
#(
  parameter int unsigned MAX_MSG = 4096
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_we,
  input  logic [2:0]           reg_addr,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  output logic                 mem_rd_req,
  output logic [31:0]          mem_rd_addr,
  input  logic                 mem_rd_valid,
  input  logic [255:0]         mem_rd_data,
  input  logic                 mem_rd_err,
  output logic                 snd_valid,
  input  logic                 snd_ready,
  output logic [15:0]          snd_dest,
  output logic [1:0]           snd_mbox,
  output logic [3:0]           snd_port,
  output logic [31:0]          snd_size,
  output logic [31:0]          snd_src,
  output logic [10:0]          snd_slot,
  output logic                 irq
);

  // named internal events, also observed by the bound checker
  logic       unit_en;
  logic [3:0] size_fld;
  ptr_t       base_ptr;
  ptr_t       enq_ptr;
  ptr_t       deq_ptr;
  logic       deq_load;
  ptr_t       deq_load_val;
  logic [7:0] status;
  logic       adv_cmd;
  logic       ovf_evt;
  logic       send_fire;
  logic       empty_evt;
  logic       terr_evt;

  obmsg_ctrl_regs u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_we       (reg_we),
    .reg_addr     (reg_addr),
    .reg_wdata    (reg_wdata),
    .reg_rdata    (reg_rdata),
    .deq_ptr      (deq_ptr),
    .evt_sent     (send_fire),
    .evt_empty    (empty_evt),
    .evt_terr     (terr_evt),
    .mode_en      (unit_en),
    .size_fld     (size_fld),
    .base_ptr     (base_ptr),
    .enq_ptr      (enq_ptr),
    .deq_load     (deq_load),
    .deq_load_val (deq_load_val),
    .status       (status),
    .irq          (irq),
    .adv_cmd      (adv_cmd),
    .ovf_evt      (ovf_evt)
  );

  obmsg_fetch_eng #(.MAX_MSG(MAX_MSG)) u_eng (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_en      (unit_en),
    .te_block     (status[SB_TERR]),
    .base_ptr     (base_ptr),
    .enq_ptr      (enq_ptr),
    .size_fld     (size_fld),
    .deq_load     (deq_load),
    .deq_load_val (deq_load_val),
    .mem_rd_req   (mem_rd_req),
    .mem_rd_addr  (mem_rd_addr),
    .mem_rd_valid (mem_rd_valid),
    .mem_rd_data  (mem_rd_data),
    .mem_rd_err   (mem_rd_err),
    .snd_valid    (snd_valid),
    .snd_ready    (snd_ready),
    .snd_dest     (snd_dest),
    .snd_mbox     (snd_mbox),
    .snd_port     (snd_port),
    .snd_size     (snd_size),
    .snd_src      (snd_src),
    .snd_slot     (snd_slot),
    .deq_ptr      (deq_ptr),
    .evt_sent     (send_fire),
    .evt_empty    (empty_evt),
    .evt_terr     (terr_evt)
  );

endmodule

// File: rtl/obmsg_ring_chk.sv
module obmsg_ring_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mem_rd_req,
  input logic        mem_rd_valid,
  input logic [31:0] mem_rd_addr,
  input logic        snd_valid,
  input logic        snd_ready,
  input logic [15:0] snd_dest,
  input logic [31:0] snd_size,
  input logic        unit_en,
  input logic        ovf_evt,
  input logic        send_fire,
  input logic [31:0] enq_ptr,
  input logic [7:0]  status
);

  assert_fetch_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req && !mem_rd_valid |=> mem_rd_req && $stable(mem_rd_addr));

  assert_send_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    snd_valid && !snd_ready |=> snd_valid && $stable(snd_dest) && $stable(snd_size));

  assert_enq_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> $stable(enq_ptr));

  assert_ovf_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> status[5]);

  assert_eom_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    send_fire |=> status[1]);

  assert_fetch_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_rd_req) |-> $past(unit_en));

  assert_err_halt_R8: assert property (@(posedge clk) disable iff (!rst_n)
    status[7] |-> !$rose(mem_rd_req));

endmodule

bind obmsg_ring obmsg_ring_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .mem_rd_req   (mem_rd_req),
  .mem_rd_valid (mem_rd_valid),
  .mem_rd_addr  (mem_rd_addr),
  .snd_valid    (snd_valid),
  .snd_ready    (snd_ready),
  .snd_dest     (snd_dest),
  .snd_size     (snd_size),
  .unit_en      (unit_en),
  .ovf_evt      (ovf_evt),
  .send_fire    (send_fire),
  .enq_ptr      (enq_ptr),
  .status       (status)
);

// File: tb/test_obmsg_ring.sv
module test_obmsg_ring;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         reg_we = 1'b0;
  logic [2:0]   reg_addr = 3'd0;
  logic [31:0]  reg_wdata = 32'h0;
  logic [31:0]  reg_rdata;
  logic         mem_rd_req;
  logic [31:0]  mem_rd_addr;
  logic         mem_rd_valid = 1'b0;
  logic [255:0] mem_rd_data = '0;
  logic         mem_rd_err = 1'b0;
  logic         snd_valid;
  logic         snd_ready = 1'b0;
  logic [15:0]  snd_dest;
  logic [1:0]   snd_mbox;
  logic [3:0]   snd_port;
  logic [31:0]  snd_size;
  logic [31:0]  snd_src;
  logic [10:0]  snd_slot;
  logic         irq;

  always #4 clk = ~clk;

  obmsg_ring i_obmsg_ring (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_rd_req(mem_rd_req),
    .mem_rd_addr(mem_rd_addr), .mem_rd_valid(mem_rd_valid),
    .mem_rd_data(mem_rd_data), .mem_rd_err(mem_rd_err), .snd_valid(snd_valid),
    .snd_ready(snd_ready), .snd_dest(snd_dest), .snd_mbox(snd_mbox),
    .snd_port(snd_port), .snd_size(snd_size), .snd_src(snd_src),
    .snd_slot(snd_slot), .irq(irq)
  );

  localparam logic [31:0] BASE     = 32'h0000_1000;
  localparam logic [31:0] MODE_OFF = 32'hA200_0000;
  localparam logic [31:0] MODE_ON  = 32'hA200_0001;

  typedef struct {
    logic [15:0] dest;
    logic [1:0]  mbox;
    logic [3:0]  port;
    logic [31:0] size;
    logic [31:0] src;
    logic [10:0] slot;
  } exp_t;

  exp_t         exp_q[$];
  logic [255:0] dmem [16];
  int           n_chk = 0;
  int           n_bad = 0;
  bit           fetch_seen = 0;
  bit           inject_err = 0;
  bit           finished = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // descriptor with junk in pad words and in unused destination bits
  task automatic load_slot(input int s, input logic [15:0] dest, input logic [1:0] mbox,
                           input logic [3:0] port, input logic [31:0] size, input bit expect_it);
    logic [31:0] w [8];
    exp_t e;
    w[0] = 32'hDEAD_BEEF;
    w[1] = 32'h8000_0000 + 32'(s) * 32'h100;
    w[2] = {dest, 14'h3FFC, mbox};
    w[3] = {8'h5A, port, 20'hABCDE};
    w[4] = 32'hFFFF_FFFF;
    w[5] = 32'h1234_5678;
    w[6] = size;
    w[7] = 32'hCAFE_F00D;
    dmem[s] = {w[7], w[6], w[5], w[4], w[3], w[2], w[1], w[0]};
    if (expect_it) begin
      e.dest = dest; e.mbox = mbox; e.port = port; e.size = size;
      e.src = w[1]; e.slot = 11'(s);
      exp_q.push_back(e);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wait_deq(input logic [31:0] target, input string tag);
    logic [31:0] v;
    v = 32'h0;
    for (int i = 0; i < 400; i++) begin
      rd(3'd2, v);
      if (v == target) break;
    end
    check(tag, v, target);
  endtask

  // memory responder: data two cycles after a request is seen
  initial begin
    int mcnt;
    int idx;
    mcnt = 0;
    forever begin
      @(negedge clk);
      if (mem_rd_valid) begin
        mem_rd_valid = 1'b0;
        mem_rd_err = 1'b0;
        mcnt = 0;
      end else if (rst_n && mem_rd_req) begin
        fetch_seen = 1;
        if (mcnt == 1) begin
          idx = int'((mem_rd_addr - BASE) >> 5) & 15;
          mem_rd_data = dmem[idx];
          mem_rd_err = inject_err;
          inject_err = 0;
          mem_rd_valid = 1'b1;
        end else begin
          mcnt++;
        end
      end
    end
  end

  // scoreboard monitor with a stalling link stub
  initial begin
    int rcnt;
    exp_t e;
    rcnt = 0;
    forever begin
      @(negedge clk);
      rcnt++;
      snd_ready = (rcnt % 3) != 0;
      if (rst_n && snd_valid && snd_ready) begin
        if (exp_q.size() == 0) begin
          n_chk++; n_bad++;
          $display("FAIL R8 unexpected send act=slot %0d exp=none", snd_slot);
        end else begin
          e = exp_q.pop_front();
          check("R5 dest", 32'(snd_dest), 32'(e.dest));
          check("R5 mbox", 32'(snd_mbox), 32'(e.mbox));
          check("R5 port", 32'(snd_port), 32'(e.port));
          check("R5 size", snd_size, e.size);
          check("R5 src",  snd_src,  e.src);
          check("R5 slot", 32'(snd_slot), 32'(e.slot));
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=running exp=done");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    rd(3'd0, v); check("R1 mode", v, MODE_OFF);
    rd(3'd1, v); check("R1 status", v, 32'h0);
    check("R1 irq", 32'(irq), 32'h0);
    check("R1 req", 32'({mem_rd_req, snd_valid}), 32'h0);

    wr(3'd4, BASE);
    wr(3'd0, MODE_OFF);
    rd(3'd2, v); check("R11 deq load", v, BASE);
    rd(3'd3, v); check("R11 enq load", v, BASE);

    load_slot(0, 16'h1111, 2'd1, 4'h3, 32'd8, 1'b0);
    load_slot(1, 16'h2222, 2'd2, 4'h5, 32'd256, 1'b0);
    load_slot(2, 16'h3333, 2'd3, 4'hA, 32'd4096, 1'b0);

    wr(3'd0, MODE_OFF | 32'h2);
    rd(3'd3, v); check("R2 advance", v, BASE + 32'h20);
    rd(3'd0, v); check("R2 self clear", v, MODE_OFF);
    wr(3'd0, MODE_OFF | 32'h2);
    wr(3'd0, MODE_OFF | 32'h2);
    rd(3'd1, v); check("R4 full", v, 32'h10);
    wr(3'd0, MODE_OFF | 32'h2);
    rd(3'd3, v); check("R3 enq held", v, BASE + 32'h60);
    rd(3'd1, v); check("R3 ovf", v, 32'h30);
    check("R10 irq ovf", 32'(irq), 32'h1);
    check("R7 no fetch", 32'(fetch_seen), 32'h0);

    wr(3'd1, 32'h30);
    rd(3'd1, v); check("R9 w1c", v, 32'h0);
    check("R10 irq low", 32'(irq), 32'h0);

    // drain three descriptors
    load_slot(0, 16'h1111, 2'd1, 4'h3, 32'd8, 1'b1);
    load_slot(1, 16'h2222, 2'd2, 4'h5, 32'd256, 1'b1);
    load_slot(2, 16'h3333, 2'd3, 4'hA, 32'd4096, 1'b1);
    wr(3'd0, MODE_ON);
    wait_deq(BASE + 32'h60, "R6 drain");
    rd(3'd1, v); check("R6 eom empty", v, 32'h03);
    check("R10 irq eom", 32'(irq), 32'h1);
    wr(3'd1, 32'h02);
    rd(3'd1, v); check("R9 partial", v, 32'h01);
    check("R10 empty masked", 32'(irq), 32'h0);

    wr(3'd2, 32'h2000);
    rd(3'd2, v); check("R11 deq ignored", v, BASE + 32'h60);
    wr(3'd4, 32'h3000);
    rd(3'd4, v); check("R11 base ignored", v, BASE);

    // wrap on both pointers
    load_slot(3, 16'h4444, 2'd0, 4'hF, 32'd16, 1'b1);
    load_slot(0, 16'h5555, 2'd1, 4'h1, 32'd64, 1'b1);
    load_slot(1, 16'h6666, 2'd2, 4'h2, 32'd2048, 1'b1);
    wr(3'd0, MODE_ON | 32'h2);
    rd(3'd3, v); check("R2 wrap", v, BASE);
    wr(3'd0, MODE_ON | 32'h2);
    wr(3'd0, MODE_ON | 32'h2);
    wait_deq(BASE + 32'h40, "R6 wrap");

    // bad size
    load_slot(2, 16'h7777, 2'd3, 4'h7, 32'd12, 1'b0);
    wr(3'd0, MODE_ON | 32'h2);
    repeat (30) @(negedge clk);
    rd(3'd1, v); check("R8 terr size", v & 32'h80, 32'h80);
    rd(3'd2, v); check("R8 deq held", v, BASE + 32'h40);
    check("R10 irq terr", 32'(irq), 32'h1);
    load_slot(2, 16'h7777, 2'd3, 4'h7, 32'd32, 1'b1);
    wr(3'd1, 32'h80);
    wait_deq(BASE + 32'h60, "R8 retry");

    // read error
    load_slot(3, 16'h8888, 2'd1, 4'h9, 32'd128, 1'b0);
    inject_err = 1;
    wr(3'd0, MODE_ON | 32'h2);
    repeat (30) @(negedge clk);
    rd(3'd1, v); check("R8 terr read", v & 32'h80, 32'h80);
    rd(3'd2, v); check("R8 deq held rd", v, BASE + 32'h60);
    load_slot(3, 16'h8888, 2'd1, 4'h9, 32'd128, 1'b1);
    wr(3'd1, 32'h80);
    wait_deq(BASE, "R8 retry rd");

    // disabled unit fetches nothing
    wr(3'd0, MODE_OFF);
    fetch_seen = 0;
    load_slot(0, 16'h9999, 2'd0, 4'h0, 32'd8, 1'b0);
    wr(3'd0, MODE_OFF | 32'h2);
    repeat (30) @(negedge clk);
    check("R7 disabled", 32'(fetch_seen), 32'h0);
    rd(3'd3, v); check("R2 enq disabled", v, BASE + 32'h20);
    check("R5 all sent", 32'(exp_q.size()), 32'h0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule